// File: doc/BRIEF.md
# Split Direction and Target Branch Predictor

This fetch-stage unit predicts, for every fetch address, whether the instruction there is a taken branch and where fetch should go next. It keeps two structures of very different sizes. A large untagged table of 2-bit saturating counters gives the direction; because it carries no tag bits it can hold far more entries than the target store in the same area. A small fully associative, tagged store keeps next-fetch addresses, and it is searched only when the counter says taken.

The lookup is purely combinational. The low PC bits select a counter. If that counter is in its upper half, the target store is searched with the word address as the tag. A match produces a taken prediction with the stored address. In every other case the prediction is not taken and the next fetch address is the sequential one.

Resolved branches come back through an update port. Every update trains the selected counter up or down. Only a taken outcome writes the target store. If the branch already has an entry, its target is overwritten. If not, a new entry is placed in the lowest free slot, or in a round-robin victim slot once the store is full. An update becomes visible at the next clock edge.

Top module: `split_branch_predictor`

## Requirements
- R1: After reset every counter holds weakly not-taken (binary 01) and the target store is empty, so every fetch address gives pred_taken=0 and pred_next=fetch_pc+4.
- R2: On each update the selected counter rises by one on a taken outcome and falls by one on a not-taken outcome. It saturates at 3 and at 0. A counter value of 2 or 3 means predict taken.
- R3: The counter is chosen by fetch_pc[11:2], so two addresses that agree in bits 11:2 share one counter.
- R4: When the counter predicts taken and the target store holds fetch_pc[31:2] as a tag, pred_taken=1 and pred_next is the stored target.
- R5: When the counter predicts taken but the target store misses, pred_taken=0 and pred_next=fetch_pc+4.
- R6: An update with a not-taken outcome never creates or changes a target store entry.
- R7: A taken update whose tag is already stored overwrites that entry's target with the resolved target.
- R8: The target store has 32 fully associative entries. A new tag takes the lowest free entry. When no entry is free, victims are chosen round-robin starting at entry 0, so the 33rd distinct branch evicts the first one installed and the 34th evicts the second.
- R9: An update takes effect at the next clock edge. A lookup in the same cycle as an update to the same entry returns the old contents.
- R10: Tags are the full fetch_pc[31:2], so addresses that share a counter but differ above bit 11 have separate targets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | 32 | Address being fetched |
| pred_taken | output | 1 | Predicted taken with a known target |
| pred_next | output | 32 | Predicted next fetch address |
| upd_valid | input | 1 | A resolved branch is presented |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |
| upd_target | input | 32 | Resolved target address |

## Verification
On every cycle, the assertions check that counters stay pinned at their limits when pushed further, that a not-taken update leaves the valid bits of the target store unchanged, that no two valid entries match one lookup, and that a taken prediction only appears together with a taken counter and a target hit. Several behaviours depend on a history of updates and can only be shown by the bench's scenarios. These are the one-edge delay of an update, the overwrite of a stale target, counter sharing under aliasing alongside separate tags, and the round-robin eviction order once all 32 entries are in use.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef logic [1:0] ctr_t;
  localparam ctr_t CTR_WEAK_NT = 2'b01;
  localparam ctr_t CTR_MAX     = 2'b11;
  localparam ctr_t CTR_MIN     = 2'b00;

  function automatic ctr_t ctr_train(input ctr_t c, input logic taken);
    if (taken) return (c == CTR_MAX) ? c : c + 2'd1;
    else       return (c == CTR_MIN) ? c : c - 2'd1;
  endfunction

  function automatic logic ctr_says_taken(input ctr_t c);
    return c[1];
  endfunction
endpackage

// File: rtl/dir_counter_table.sv
module dir_counter_table
  import bp_pkg::*;
#(
  parameter int ENTRIES = 1024,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_taken,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);
  ctr_t ctr_q [ENTRIES];
  ctr_t ctr_d;

  assign rd_taken = ctr_says_taken(ctr_q[rd_idx]);
  assign ctr_d    = ctr_train(ctr_q[wr_idx], wr_taken);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ctr
    logic en;
    assign en = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ctr_q[g] <= CTR_WEAK_NT;
      else if (en) ctr_q[g] <= ctr_d;
    end
  end

  assert_sat_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_taken && ctr_q[wr_idx] == CTR_MAX) |=> ctr_q[$past(wr_idx)] == CTR_MAX);
  assert_sat_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_taken && ctr_q[wr_idx] == CTR_MIN) |=> ctr_q[$past(wr_idx)] == CTR_MIN);
endmodule

// File: rtl/target_store.sv
module target_store #(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 32,
  localparam int TAG_W  = PC_W - 2,
  localparam int SLOT_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  output logic [PC_W-1:0]  lk_target,
  input  logic             upd_en,
  input  logic             upd_taken,
  input  logic [TAG_W-1:0] upd_tag,
  input  logic [PC_W-1:0]  upd_target
);
  logic [ENTRIES-1:0] valid_q, valid_d;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [PC_W-1:0]    tgt_q [ENTRIES];
  logic [SLOT_W-1:0]  rr_q, rr_d;

  logic [ENTRIES-1:0] lk_vec, up_vec, wr_sel;
  logic               up_hit, has_free, alloc_en;
  logic [SLOT_W-1:0]  up_slot, free_slot, victim;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lk_vec[g] = valid_q[g] && (tag_q[g] == lk_tag);
    assign up_vec[g] = valid_q[g] && (tag_q[g] == upd_tag);
  end

  assign lk_hit = |lk_vec;
  assign up_hit = |up_vec;

  always_comb begin
    lk_target = '0;
    up_slot   = '0;
    free_slot = '0;
    has_free  = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lk_vec[i]) lk_target = lk_target | tgt_q[i];
      if (up_vec[i]) up_slot   = SLOT_W'(i);
      if (!valid_q[i]) begin
        free_slot = SLOT_W'(i);
        has_free  = 1'b1;
      end
    end
  end

  // Next-state: pick the slot to write and advance the round-robin pointer
  always_comb begin
    alloc_en = upd_en && upd_taken && !up_hit;
    victim   = has_free ? free_slot : rr_q;
    wr_sel   = '0;
    if (upd_en && upd_taken)
      wr_sel[up_hit ? up_slot : victim] = 1'b1;
    valid_d = valid_q | wr_sel;
    rr_d    = rr_q;
    if (alloc_en && !has_free)
      rr_d = (rr_q == SLOT_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      rr_q    <= '0;
    end else begin
      valid_q <= valid_d;
      rr_q    <= rr_d;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_q[g] <= '0;
        tgt_q[g] <= '0;
      end else if (wr_sel[g]) begin
        tag_q[g] <= upd_tag;
        tgt_q[g] <= upd_target;
      end
    end
  end

  assert_single_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_vec));
  assert_nt_no_install_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !upd_taken) |=> $stable(valid_q));
endmodule

// File: rtl/split_branch_predictor.sv
module split_branch_predictor #(
  parameter int PC_W        = 32,
  parameter int DIR_ENTRIES = 1024,
  parameter int TGT_ENTRIES = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            pred_taken,
  output logic [PC_W-1:0] pred_next,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_target
);
  localparam int IDX_W = $clog2(DIR_ENTRIES);
  localparam int TAG_W = PC_W - 2;

  logic            dir_taken, tb_hit;
  logic [PC_W-1:0] tb_target;

  dir_counter_table #(.ENTRIES(DIR_ENTRIES)) i_dir (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (fetch_pc[IDX_W+1:2]),
    .rd_taken(dir_taken),
    .wr_en   (upd_valid),
    .wr_idx  (upd_pc[IDX_W+1:2]),
    .wr_taken(upd_taken)
  );

  target_store #(.PC_W(PC_W), .ENTRIES(TGT_ENTRIES)) i_tgt (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_tag    (fetch_pc[PC_W-1:2]),
    .lk_hit    (tb_hit),
    .lk_target (tb_target),
    .upd_en    (upd_valid),
    .upd_taken (upd_taken),
    .upd_tag   (upd_pc[PC_W-1:2]),
    .upd_target(upd_target)
  );

  // The target store result is used only behind a taken counter
  always_comb begin
    pred_taken = dir_taken && tb_hit;
    pred_next  = pred_taken ? tb_target : fetch_pc + PC_W'(4);
  end

  assert_taken_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pred_taken |-> (dir_taken && tb_hit));
  assert_seq_on_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_taken && !tb_hit) |-> (!pred_taken && pred_next == fetch_pc + PC_W'(4)));
endmodule

// File: tb/test_split_branch_predictor.sv
`timescale 1ns/1ps
module test_split_branch_predictor;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] fetch_pc;
  logic        pred_taken;
  logic [31:0] pred_next;
  logic        upd_valid;
  logic [31:0] upd_pc;
  logic        upd_taken;
  logic [31:0] upd_target;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  split_branch_predictor i_split_branch_predictor (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
    .pred_taken(pred_taken), .pred_next(pred_next),
    .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_target(upd_target)
  );

  localparam logic [31:0] PA = 32'h0000_0100;
  localparam logic [31:0] PB = 32'h0000_1100;  // same counter as PA, new tag
  localparam logic [31:0] PC = 32'h0000_2100;  // same counter as PA, new tag
  localparam logic [31:0] T1 = 32'h0000_8000;
  localparam logic [31:0] T2 = 32'h0000_9000;
  localparam logic [31:0] TB = 32'h0000_A000;

  typedef struct packed {
    logic [23:0] req;
    logic        upd;
    logic [31:0] upd_pc;
    logic        upd_t;
    logic [31:0] upd_tgt;
    logic [31:0] lk_pc;
    logic        exp_t;
    logic [31:0] exp_n;
  } vec_t;

  // Lookup is checked before the edge that commits the row's update
  localparam vec_t VECS [17] = '{
    '{"R1",  1'b0, 32'h0, 1'b0, 32'h0, PA, 1'b0, PA + 4},
    '{"R9",  1'b1, PA,    1'b1, T1,    PA, 1'b0, PA + 4},
    '{"R4",  1'b0, 32'h0, 1'b0, 32'h0, PA, 1'b1, T1},
    '{"R9",  1'b1, PA,    1'b1, T2,    PA, 1'b1, T1},
    '{"R7",  1'b1, PA,    1'b1, T2,    PA, 1'b1, T2},
    '{"R2",  1'b1, PA,    1'b0, 32'h0, PA, 1'b1, T2},
    '{"R2",  1'b1, PA,    1'b0, 32'h0, PA, 1'b1, T2},
    '{"R2",  1'b0, 32'h0, 1'b0, 32'h0, PA, 1'b0, PA + 4},
    '{"R2",  1'b1, PA,    1'b0, 32'h0, PA, 1'b0, PA + 4},
    '{"R2",  1'b1, PA,    1'b0, 32'h0, PA, 1'b0, PA + 4},
    '{"R2",  1'b0, 32'h0, 1'b0, 32'h0, PA, 1'b0, PA + 4},
    '{"R6",  1'b1, PC,    1'b0, 32'h0, PC, 1'b0, PC + 4},
    '{"R3",  1'b1, PB,    1'b1, TB,    PB, 1'b0, PB + 4},
    '{"R3",  1'b1, PB,    1'b1, TB,    PB, 1'b0, PB + 4},
    '{"R10", 1'b0, 32'h0, 1'b0, 32'h0, PB, 1'b1, TB},
    '{"R5",  1'b0, 32'h0, 1'b0, 32'h0, PC, 1'b0, PC + 4},
    '{"R10", 1'b0, 32'h0, 1'b0, 32'h0, PA, 1'b1, T2}
  };

  task automatic check(input string req, input logic exp_t, input logic [31:0] exp_n);
    checks++;
    if (pred_taken !== exp_t || pred_next !== exp_n) begin
      errors++;
      $display("FAIL %s pc=%h: taken=%b next=%h expected taken=%b next=%h",
               req, fetch_pc, pred_taken, pred_next, exp_t, exp_n);
    end
  endtask

  task automatic step(input logic u, input logic [31:0] up, input logic ut,
                      input logic [31:0] utg, input logic [31:0] lk);
    @(negedge clk);
    upd_valid = u; upd_pc = up; upd_taken = ut; upd_target = utg; fetch_pc = lk;
    #1;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; upd_valid = 1'b0; upd_pc = '0; upd_taken = 1'b0;
    upd_target = '0; fetch_pc = PA;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    foreach (VECS[i]) begin
      step(VECS[i].upd, VECS[i].upd_pc, VECS[i].upd_t, VECS[i].upd_tgt, VECS[i].lk_pc);
      check(string'(VECS[i].req), VECS[i].exp_t, VECS[i].exp_n);
    end

    // R8: fill the remaining 30 slots with distinct taken branches
    for (int k = 0; k < 30; k++)
      step(1'b1, 32'h0001_0800 + 32'(4 * k), 1'b1, 32'h0000_5000 + 32'(4 * k), PA);
    step(1'b0, 0, 1'b0, 0, PA);
    check("R8", 1'b1, T2);
    step(1'b0, 0, 1'b0, 0, 32'h0001_0800 + 32'(4 * 29));
    check("R8", 1'b1, 32'h0000_5000 + 32'(4 * 29));
    // 33rd branch evicts the first installed (PA)
    step(1'b1, 32'h0002_0A00, 1'b1, 32'h0000_6000, PA);
    step(1'b0, 0, 1'b0, 0, PA);
    check("R8", 1'b0, PA + 4);
    step(1'b0, 0, 1'b0, 0, PB);
    check("R8", 1'b1, TB);
    // 34th branch evicts the second installed (PB)
    step(1'b1, 32'h0002_0A04, 1'b1, 32'h0000_6004, PB);
    step(1'b0, 0, 1'b0, 0, PB);
    check("R8", 1'b0, PB + 4);
    step(1'b0, 0, 1'b0, 0, 32'h0001_0800);
    check("R8", 1'b1, 32'h0000_5000);
    step(1'b0, 0, 1'b0, 0, 32'h0002_0A00);
    check("R8", 1'b1, 32'h0000_6000);
    step(1'b0, 0, 1'b0, 0, 32'h0002_0A04);
    check("R8", 1'b1, 32'h0000_6004);

    // R1: reset again mid-run clears counters and targets
    @(negedge clk) rst_n = 1'b0;
    upd_valid = 1'b0;
    fetch_pc = 32'h0001_0800;
    #1;
    check("R1", 1'b0, 32'h0001_0804);
    @(negedge clk) rst_n = 1'b1;
    step(1'b0, 0, 1'b0, 0, 32'h0002_0A00);
    check("R1", 1'b0, 32'h0002_0A04);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule